// File: doc/BRIEF.md
# Remote Memory Command Decoder

The decoder sits behind one router port and takes arriving packets as a byte stream, one byte per accepted cycle, with a flag on the final byte. The first byte of every packet is a protocol identifier. Packets carrying any identifier other than 1 go straight to a host-side FIFO write port, byte for byte. Packets with identifier 1 are remote memory commands: the decoder checks a header checksum, a per-node access key and the command fields. It then performs a read, a write or an atomic read-modify-write on a byte-wide local bus, and can return a short reply packet that carries a status code.

Command layout, in byte order: identifier (1), instruction, key, start address, length, header checksum, then for writes the data bytes and for read-modify-write the value bytes followed by the same number of mask bytes, and finally a data checksum. Instruction bits [7:6] select the operation (01 read, 10 write, 11 read-modify-write, 00 undefined). Bit 5 requests a verified write and bit 4 requests a reply. Bits [3:0] are carried into the reply and have no other effect. One bus address, `CFG_ADDR`, is never placed on the bus: it maps to an internal configuration byte that is visible on `cfg_out`.

Top module: `rmap_decoder`

## Requirements
- R1: A packet whose first byte is not 1 is copied to the host port unchanged. Each accepted byte appears on `host_data` one cycle after acceptance, and `host_last` marks the final byte. Such a packet produces no bus access and no reply.
- R2: A read with a valid header returns, in its reply, the `length` bytes stored at the start address and the following addresses. Addresses wrap at the address width.
- R3: Both checksums are CRC-8 with polynomial 0x07, MSB first and start value 0. The header checksum byte must equal the CRC over the first five bytes. On a mismatch the status is 1 and the bus is not touched.
- R4: If the key byte differs from `node_key`, the status is 3 and the bus is not touched. Header checksum errors take precedence over key errors.
- R5: An undefined operation (00), a length of 0 or a length above `MAX_LEN` gives status 4 and no bus access.
- R6: A verified write commits nothing until the data checksum (the CRC over the data bytes) has matched. On a mismatch the status is 2 and memory is unchanged.
- R7: An unverified write commits each data byte in the cycle it is accepted. A data checksum mismatch still gives status 2, and the written bytes remain.
- R8: A read-modify-write stores (old AND NOT mask) OR (value AND mask) at each address and returns the old bytes in the reply. A read-modify-write is always verified: with a bad data checksum nothing is written.
- R9: A reply is produced only when instruction bit 4 is set. Its bytes are: 1, the instruction, the status, the address, the read or old data (only for a successful read or read-modify-write), and then the CRC over all preceding reply bytes.
- R10: A command packet that ends before its header checksum byte is dropped without a reply, host output or bus access.
- R11: Writes to `CFG_ADDR` update `cfg_out` instead of the bus, and reads of `CFG_ADDR` return `cfg_out`.
- R12: Bytes that follow the data checksum (or the header of a read or rejected command) are discarded without changing the outcome. `rx_ready` is low while a command executes or a reply is sent.
- R13: After reset, `rx_ready` is 1, `cfg_out` is 0, and the host, reply and bus strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_key | input | 8 | Access key of this node |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends its packet |
| rx_ready | output | 1 | Decoder accepts a byte this cycle |
| host_valid | output | 1 | Forwarded byte valid (FIFO push) |
| host_data | output | 8 | Forwarded byte |
| host_last | output | 1 | Forwarded byte ends its packet |
| rep_valid | output | 1 | Reply byte valid |
| rep_data | output | 8 | Reply byte |
| rep_last | output | 1 | Reply byte ends the reply |
| mem_en | output | 1 | Bus access strobe |
| mem_we | output | 1 | Bus write enable |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data, valid in the cycle of the access |
| cfg_out | output | 8 | Configuration byte |

## Verification
A forwarded byte is due exactly one cycle after the edge that accepts it, and the bench compares each host byte against the byte it recorded at that edge. Unverified write data reaches the bus in the accepting cycle. Verified writes and read-modify-writes run one byte per cycle after the last packet byte, and the reply starts once those cycles are done. The bench therefore collects reply bytes from every cycle, waits until the decoder is ready again plus a margin, and only then compares the reply, the whole memory image and `cfg_out` with its own model. This keeps the checks independent of the exact execute latency.

// File: rtl/rmd_pkg.sv
package rmd_pkg;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_FWD,
        ST_DATA,
        ST_SKIP,
        ST_EXEC,
        ST_REPLY
    } st_e;

    localparam logic [7:0] PID_CMD  = 8'h01;

    localparam logic [1:0] K_NONE   = 2'd0;
    localparam logic [1:0] K_READ   = 2'd1;
    localparam logic [1:0] K_WRITE  = 2'd2;
    localparam logic [1:0] K_RMW    = 2'd3;

    localparam logic [7:0] SC_OK    = 8'd0;
    localparam logic [7:0] SC_HCRC  = 8'd1;
    localparam logic [7:0] SC_DCRC  = 8'd2;
    localparam logic [7:0] SC_KEY   = 8'd3;
    localparam logic [7:0] SC_CMD   = 8'd4;

    localparam logic [2:0] HDR_CRC_IDX = 3'd5;

endpackage

// File: rtl/rmd_crc8.sv
module rmd_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    logic [7:0] stage [0:8];

    assign stage[0] = crc_in ^ data_in;

    for (genvar g = 0; g < 8; g++) begin : g_bit
        assign stage[g+1] = stage[g][7] ? ({stage[g][6:0], 1'b0} ^ POLY)
                                        :  {stage[g][6:0], 1'b0};
    end

    assign crc_out = stage[8];
endmodule

// File: rtl/rmd_merge.sv
module rmd_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] mask,
    input  logic         sel_rmw,
    output logic [W-1:0] result
);
    always_comb begin
        if (sel_rmw) result = (old_val & ~mask) | (new_val & mask);
        else         result = new_val;
    end
endmodule

// File: rtl/rmap_decoder.sv
module rmap_decoder
    import rmd_pkg::*;
#(
    parameter int unsigned   AW       = 8,   // at most 8
    parameter int unsigned   MAX_LEN  = 4,   // at least 2
    parameter logic [AW-1:0] CFG_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    node_key,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    output logic          rx_ready,
    output logic          host_valid,
    output logic [7:0]    host_data,
    output logic          host_last,
    output logic          rep_valid,
    output logic [7:0]    rep_data,
    output logic          rep_last,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic [7:0]    cfg_out
);
    localparam int DBN = 2 * MAX_LEN;
    localparam int DIW = $clog2(DBN);
    localparam int CW  = $clog2(DBN + 1);
    localparam int LW  = $clog2(MAX_LEN + 1);
    localparam int LIW = $clog2(MAX_LEN);
    localparam int RW  = $clog2(MAX_LEN + 6);

    typedef struct packed {
        st_e                      st;
        logic [2:0]               hcnt;
        logic [7:0]               instr;
        logic [7:0]               key;
        logic [AW-1:0]            addr;
        logic [7:0]               len;
        logic [7:0]               crc;
        logic [7:0]               status;
        logic [CW-1:0]            dcnt;
        logic [LW-1:0]            ecnt;
        logic [RW-1:0]            rcnt;
        logic [DBN-1:0][7:0]      dbuf;
        logic [MAX_LEN-1:0][7:0]  rbuf;
        logic                     host_v;
        logic [7:0]               host_d;
        logic                     host_l;
        logic                     rep_v;
        logic [7:0]               rep_d;
        logic                     rep_l;
        logic [7:0]               cfg;
    } state_t;

    state_t q, n;

    logic          acc;
    logic [1:0]    kind;
    logic          verify, ack;
    logic [8:0]    need;
    logic          has_data;
    logic [7:0]    rlast;
    logic [7:0]    rep_byte;
    logic [7:0]    crc_rx, crc_tx;
    logic [AW-1:0] dwa, ea;
    logic [7:0]    old_c, val_c, mask_c, wdata_m;
    logic [DIW-1:0] midx;
    logic [LIW-1:0] ridx;
    logic [7:0]    hstat;
    logic          len_ok;

    logic          mem_en_c, mem_we_c;
    logic [AW-1:0] mem_addr_c;
    logic [7:0]    mem_wdata_c;

    assign rx_ready = (q.st == ST_HDR) || (q.st == ST_FWD) ||
                      (q.st == ST_DATA) || (q.st == ST_SKIP);
    assign acc      = rx_valid && rx_ready;

    assign kind     = q.instr[7:6];
    assign verify   = q.instr[5];
    assign ack      = q.instr[4];
    assign need     = (kind == K_RMW) ? {q.len, 1'b0} : {1'b0, q.len};
    assign has_data = (q.status == SC_OK) && ((kind == K_READ) || (kind == K_RMW));
    assign rlast    = 8'd4 + (has_data ? q.len : 8'd0);

    assign dwa      = q.addr + AW'(q.dcnt);
    assign ea       = q.addr + AW'(q.ecnt);
    assign old_c    = (ea == CFG_ADDR) ? q.cfg : mem_rdata;
    assign midx     = DIW'(q.len + 8'(q.ecnt));
    assign val_c    = q.dbuf[DIW'(q.ecnt)];
    assign mask_c   = q.dbuf[midx];
    assign ridx     = LIW'(8'(q.rcnt) - 8'd4);
    assign len_ok   = (q.len != 8'd0) && (q.len <= 8'(MAX_LEN));

    // header verdict, computed while the header checksum byte is on rx_data
    always_comb begin
        if (rx_data != q.crc)                   hstat = SC_HCRC;
        else if (q.key != node_key)             hstat = SC_KEY;
        else if (kind == K_NONE || !len_ok)     hstat = SC_CMD;
        else                                    hstat = SC_OK;
    end

    always_comb begin
        if (q.rcnt == RW'(0))           rep_byte = PID_CMD;
        else if (q.rcnt == RW'(1))      rep_byte = q.instr;
        else if (q.rcnt == RW'(2))      rep_byte = q.status;
        else if (q.rcnt == RW'(3))      rep_byte = 8'(q.addr);
        else if (8'(q.rcnt) == rlast)   rep_byte = q.crc;
        else                            rep_byte = q.rbuf[ridx];
    end

    rmd_crc8 #(.POLY(8'h07)) u_crc_rx (
        .crc_in (q.crc),
        .data_in(rx_data),
        .crc_out(crc_rx)
    );

    rmd_crc8 #(.POLY(8'h07)) u_crc_tx (
        .crc_in (q.crc),
        .data_in(rep_byte),
        .crc_out(crc_tx)
    );

    rmd_merge #(.W(8)) u_merge (
        .old_val(old_c),
        .new_val(val_c),
        .mask   (mask_c),
        .sel_rmw(kind == K_RMW),
        .result (wdata_m)
    );

    always_comb begin
        n           = q;
        n.host_v    = 1'b0;
        n.host_l    = 1'b0;
        n.rep_v     = 1'b0;
        n.rep_l     = 1'b0;
        mem_en_c    = 1'b0;
        mem_we_c    = 1'b0;
        mem_addr_c  = '0;
        mem_wdata_c = '0;

        unique case (q.st)
            ST_HDR: if (acc) begin
                if (q.hcnt == 3'd0 && rx_data != PID_CMD) begin
                    n.host_v = 1'b1;
                    n.host_d = rx_data;
                    n.host_l = rx_last;
                    if (!rx_last) n.st = ST_FWD;
                end else if (q.hcnt == HDR_CRC_IDX) begin
                    n.hcnt   = 3'd0;
                    n.crc    = 8'd0;
                    n.dcnt   = '0;
                    n.ecnt   = '0;
                    n.status = hstat;
                    if (hstat != SC_OK || kind == K_READ) begin
                        n.st = rx_last ? ST_EXEC : ST_SKIP;
                    end else if (rx_last) begin
                        n.status = SC_DCRC;
                        n.st     = ST_EXEC;
                    end else begin
                        n.st = ST_DATA;
                    end
                end else begin
                    n.crc = crc_rx;
                    case (q.hcnt)
                        3'd1:    n.instr = rx_data;
                        3'd2:    n.key   = rx_data;
                        3'd3:    n.addr  = rx_data[AW-1:0];
                        3'd4:    n.len   = rx_data;
                        default: ;
                    endcase
                    if (rx_last) begin
                        n.hcnt = 3'd0;
                        n.crc  = 8'd0;
                    end else begin
                        n.hcnt = 3'(q.hcnt + 3'd1);
                    end
                end
            end

            ST_FWD: if (acc) begin
                n.host_v = 1'b1;
                n.host_d = rx_data;
                n.host_l = rx_last;
                if (rx_last) n.st = ST_HDR;
            end

            ST_DATA: if (acc) begin
                if (9'(q.dcnt) < need) begin
                    n.dbuf[DIW'(q.dcnt)] = rx_data;
                    n.crc  = crc_rx;
                    n.dcnt = CW'(q.dcnt + CW'(1));
                    if (kind == K_WRITE && !verify) begin
                        if (dwa == CFG_ADDR) begin
                            n.cfg = rx_data;
                        end else begin
                            mem_en_c    = 1'b1;
                            mem_we_c    = 1'b1;
                            mem_addr_c  = dwa;
                            mem_wdata_c = rx_data;
                        end
                    end
                    if (rx_last) begin
                        n.status = SC_DCRC;
                        n.st     = ST_EXEC;
                    end
                end else begin
                    n.status = (rx_data == q.crc) ? SC_OK : SC_DCRC;
                    n.st     = rx_last ? ST_EXEC : ST_SKIP;
                end
            end

            ST_SKIP: if (acc && rx_last) n.st = ST_EXEC;

            ST_EXEC: begin
                if (q.status != SC_OK || (kind == K_WRITE && !verify) ||
                    8'(q.ecnt) >= q.len) begin
                    n.crc  = 8'd0;
                    n.rcnt = '0;
                    n.st   = ack ? ST_REPLY : ST_HDR;
                end else begin
                    n.ecnt = LW'(q.ecnt + LW'(1));
                    if (kind != K_WRITE) n.rbuf[LIW'(q.ecnt)] = old_c;
                    if (ea != CFG_ADDR) begin
                        mem_en_c   = 1'b1;
                        mem_addr_c = ea;
                    end
                    if (kind != K_READ) begin
                        if (ea == CFG_ADDR) begin
                            n.cfg = wdata_m;
                        end else begin
                            mem_we_c    = 1'b1;
                            mem_wdata_c = wdata_m;
                        end
                    end
                end
            end

            ST_REPLY: begin
                n.rep_v = 1'b1;
                n.rep_d = rep_byte;
                n.crc   = crc_tx;
                n.rcnt  = RW'(q.rcnt + RW'(1));
                if (8'(q.rcnt) == rlast) begin
                    n.rep_l = 1'b1;
                    n.crc   = 8'd0;
                    n.st    = ST_HDR;
                end
            end

            default: n.st = ST_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_HDR;
        end else begin
            q <= n;
        end
    end

    assign host_valid = q.host_v;
    assign host_data  = q.host_d;
    assign host_last  = q.host_l;
    assign rep_valid  = q.rep_v;
    assign rep_data   = q.rep_d;
    assign rep_last   = q.rep_l;
    assign cfg_out    = q.cfg;
    assign mem_en     = mem_en_c;
    assign mem_we     = mem_we_c;
    assign mem_addr   = mem_addr_c;
    assign mem_wdata  = mem_wdata_c;

    // R1
    host_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |-> ($past(rx_valid && rx_ready) && host_data == $past(rx_data)));

    // R11
    cfg_off_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr != CFG_ADDR));

    // R9
    reply_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rep_valid) |-> (rep_data == PID_CMD));

    // R12
    busy_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && !rep_last) |-> !rx_ready);

    // R1
    fwd_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FWD) |-> !mem_en);

endmodule

// File: tb/sim_rmap_decoder.sv
module sim_rmap_decoder;
    localparam int          AW   = 8;
    localparam int          MAXL = 4;
    localparam logic [7:0]  CFGA = 8'hFF;
    localparam logic [7:0]  KEY  = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] node_key = KEY;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_last = 1'b0;
    logic       rx_ready;
    logic       host_valid, host_last, rep_valid, rep_last;
    logic [7:0] host_data, rep_data;
    logic       mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, cfg_out;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem_m   [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_cfg = 8'h00;
    logic [7:0] pkt [64];
    int         plen;
    logic [7:0] rq[$];
    logic [7:0] hq[$];
    logic       hl[$];
    logic       acc_d = 1'b0;
    logic [7:0] acc_data = 8'h00;

    always #5 clk = ~clk;

    rmap_decoder #(.AW(AW), .MAX_LEN(MAXL), .CFG_ADDR(CFGA)) u0 (
        .clk(clk), .rst_n(rst_n), .node_key(node_key),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .host_valid(host_valid), .host_data(host_data), .host_last(host_last),
        .rep_valid(rep_valid), .rep_data(rep_data), .rep_last(rep_last),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cfg_out(cfg_out)
    );

    assign mem_rdata = mem_m[mem_addr];
    always @(posedge clk) if (mem_en && mem_we) mem_m[mem_addr] <= mem_wdata;

    always @(posedge clk) begin
        acc_d    <= rx_valid && rx_ready;
        acc_data <= rx_data;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rep_valid) rq.push_back(rep_data);
        if (host_valid) begin
            hq.push_back(host_data);
            hl.push_back(host_last);
            if (!(acc_d && acc_data == host_data))
                chk(1'b0, "R1 host byte timing", int'(host_data), int'(acc_data));
        end
    end

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    function automatic logic [7:0] rd(input logic [7:0] a);
        return (a == CFGA) ? exp_cfg : exp_mem[a];
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        if (a == CFGA) exp_cfg = v;
        else exp_mem[a] = v;
    endtask

    task automatic send_pkt();
        @(negedge clk);
        for (int i = 0; i < plen; i++) begin
            rx_valid = 1'b1;
            rx_data  = pkt[i];
            rx_last  = (i == plen - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (!rx_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_mem(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem_m[i] !== exp_mem[i]) bad++;
        chk(bad == 0, req, bad, 0);
        chk(cfg_out === exp_cfg, req, int'(cfg_out), int'(exp_cfg));
    endtask

    task automatic check_reply(input logic [7:0] er[$], input string req);
        int bad;
        chk(rq.size() == er.size(), req, rq.size(), er.size());
        bad = 0;
        if (rq.size() == er.size())
            for (int i = 0; i < er.size(); i++) if (rq[i] !== er[i]) bad++;
        chk(bad == 0, req, bad, 0);
        chk(hq.size() == 0, req, hq.size(), 0);
        rq.delete(); hq.delete(); hl.delete();
    endtask

    task automatic run_cmd(input logic [1:0] kind, input bit ver, input bit ack,
                           input logic [7:0] key, input logic [7:0] addr, input logic [7:0] len,
                           input bit bad_h, input bit bad_d, input int extra, input string req);
        logic [7:0] instr, c, st, old, v, m;
        logic [7:0] dv [8];
        logic [7:0] er[$];
        logic [7:0] rdv[$];
        int nd;
        instr = {kind, ver, ack, 4'($urandom)};
        pkt[0] = 8'h01; pkt[1] = instr; pkt[2] = key; pkt[3] = addr; pkt[4] = len;
        c = 8'h00;
        for (int i = 0; i < 5; i++) c = crc8(c, pkt[i]);
        pkt[5] = c ^ {7'b0, bad_h};
        plen = 6;
        nd = 0;
        if ((kind == 2'd2 || kind == 2'd3) && len >= 1 && len <= MAXL)
            nd = (kind == 2'd3) ? 2 * int'(len) : int'(len);
        if (nd > 0) begin
            c = 8'h00;
            for (int i = 0; i < nd; i++) begin
                dv[i] = 8'($urandom);
                pkt[plen] = dv[i]; plen++;
                c = crc8(c, dv[i]);
            end
            pkt[plen] = c ^ {7'b0, bad_d}; plen++;
        end
        for (int i = 0; i < extra; i++) begin pkt[plen] = 8'($urandom); plen++; end

        if (bad_h) st = 8'd1;
        else if (key != KEY) st = 8'd3;
        else if (kind == 2'd0 || len == 0 || len > MAXL) st = 8'd4;
        else st = 8'd0;
        if (st == 8'd0 && nd > 0 && bad_d) st = 8'd2;

        if (kind == 2'd2 && !ver && nd > 0 && (st == 8'd0 || st == 8'd2)) begin
            for (int i = 0; i < nd; i++) wr(addr + 8'(i), dv[i]);
        end else if (st == 8'd0) begin
            for (int i = 0; i < int'(len); i++) begin
                old = rd(addr + 8'(i));
                if (kind == 2'd1) rdv.push_back(old);
                else if (kind == 2'd2) wr(addr + 8'(i), dv[i]);
                else begin
                    v = dv[i]; m = dv[i + int'(len)];
                    rdv.push_back(old);
                    wr(addr + 8'(i), (old & ~m) | (v & m));
                end
            end
        end

        if (ack) begin
            er.push_back(8'h01); er.push_back(instr); er.push_back(st); er.push_back(addr);
            for (int i = 0; i < rdv.size(); i++) er.push_back(rdv[i]);
            c = 8'h00;
            for (int i = 0; i < er.size(); i++) c = crc8(c, er[i]);
            er.push_back(c);
        end

        send_pkt();
        wait_idle();
        check_reply(er, req);
        check_mem(req);
    endtask

    task automatic run_fwd(input int n, input string req);
        int bad;
        pkt[0] = 8'($urandom);
        if (pkt[0] == 8'h01) pkt[0] = 8'h02;
        for (int i = 1; i < n; i++) pkt[i] = 8'($urandom);
        plen = n;
        send_pkt();
        wait_idle();
        chk(hq.size() == n, req, hq.size(), n);
        bad = 0;
        if (hq.size() == n)
            for (int i = 0; i < n; i++)
                if (hq[i] !== pkt[i] || hl[i] !== (i == n - 1)) bad++;
        chk(bad == 0, req, bad, 0);
        chk(rq.size() == 0, req, rq.size(), 0);
        rq.delete(); hq.delete(); hl.delete();
        check_mem(req);
    endtask

    task automatic run_trunc(input int n, input string req);
        pkt[0] = 8'h01;
        pkt[1] = 8'h90; pkt[2] = KEY; pkt[3] = 8'h10; pkt[4] = 8'h02;
        plen = n;
        send_pkt();
        wait_idle();
        chk(rq.size() == 0 && hq.size() == 0, req, rq.size() + hq.size(), 0);
        rq.delete(); hq.delete(); hl.delete();
        check_mem(req);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R12 watchdog", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            v = 8'($urandom);
            mem_m[i] = v;
            exp_mem[i] = v;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(rx_ready === 1'b1, "R13 rx_ready", int'(rx_ready), 1);
        chk(host_valid === 1'b0 && rep_valid === 1'b0, "R13 strobes", int'({host_valid, rep_valid}), 0);
        chk(mem_en === 1'b0, "R13 mem_en", int'(mem_en), 0);
        chk(cfg_out === 8'h00, "R13 cfg_out", int'(cfg_out), 0);

        // R1 foreign packets, single byte and longer
        run_fwd(1, "R1 fwd single");
        for (int i = 0; i < 4; i++) run_fwd(2 + int'($urandom % 7), "R1 fwd");

        // R2 read, including wrap across the top address
        run_cmd(2'd1, 1'b0, 1'b1, KEY, 8'h20, 8'd4, 1'b0, 1'b0, 0, "R2 read");
        run_cmd(2'd1, 1'b0, 1'b1, KEY, 8'hFE, 8'd3, 1'b0, 1'b0, 0, "R2 read wrap");
        // R3 header checksum error on a write
        run_cmd(2'd2, 1'b1, 1'b1, KEY, 8'h30, 8'd2, 1'b1, 1'b0, 0, "R3 hdr crc");
        // R4 key mismatch, and header error taking precedence
        run_cmd(2'd2, 1'b0, 1'b1, 8'hA5, 8'h31, 8'd2, 1'b0, 1'b0, 0, "R4 key");
        run_cmd(2'd2, 1'b0, 1'b1, 8'hA5, 8'h31, 8'd2, 1'b1, 1'b0, 0, "R4 precedence");
        // R5 undefined command, zero and oversize length
        run_cmd(2'd0, 1'b0, 1'b1, KEY, 8'h40, 8'd2, 1'b0, 1'b0, 0, "R5 kind");
        run_cmd(2'd1, 1'b0, 1'b1, KEY, 8'h40, 8'd0, 1'b0, 1'b0, 0, "R5 zero len");
        run_cmd(2'd2, 1'b1, 1'b1, KEY, 8'h40, 8'd6, 1'b0, 1'b0, 0, "R5 long");
        // R6 verified write good and bad
        run_cmd(2'd2, 1'b1, 1'b1, KEY, 8'h50, 8'd4, 1'b0, 1'b0, 0, "R6 vwrite");
        run_cmd(2'd2, 1'b1, 1'b1, KEY, 8'h58, 8'd3, 1'b0, 1'b1, 0, "R6 vwrite bad");
        // R7 unverified write good and bad
        run_cmd(2'd2, 1'b0, 1'b1, KEY, 8'h60, 8'd4, 1'b0, 1'b0, 0, "R7 uwrite");
        run_cmd(2'd2, 1'b0, 1'b1, KEY, 8'h68, 8'd2, 1'b0, 1'b1, 0, "R7 uwrite bad");
        // R8 read-modify-write good and bad
        run_cmd(2'd3, 1'b0, 1'b1, KEY, 8'h70, 8'd4, 1'b0, 1'b0, 0, "R8 rmw");
        run_cmd(2'd3, 1'b1, 1'b1, KEY, 8'h78, 8'd2, 1'b0, 1'b1, 0, "R8 rmw bad");
        // R9 no reply without the acknowledge bit
        run_cmd(2'd2, 1'b1, 1'b0, KEY, 8'h80, 8'd2, 1'b0, 1'b0, 0, "R9 no ack");
        run_cmd(2'd1, 1'b0, 1'b0, KEY, 8'h80, 8'd2, 1'b0, 1'b0, 0, "R9 no ack read");
        // R10 truncated headers
        for (int n = 1; n <= 5; n++) run_trunc(n, "R10 truncated");
        // R11 configuration byte through write, read and rmw
        run_cmd(2'd2, 1'b1, 1'b1, KEY, 8'hFE, 8'd2, 1'b0, 1'b0, 0, "R11 cfg write");
        run_cmd(2'd1, 1'b0, 1'b1, KEY, 8'hFF, 8'd1, 1'b0, 1'b0, 0, "R11 cfg read");
        run_cmd(2'd3, 1'b0, 1'b1, KEY, 8'hFF, 8'd2, 1'b0, 1'b0, 0, "R11 cfg rmw");
        run_cmd(2'd2, 1'b0, 1'b1, KEY, 8'hFD, 8'd3, 1'b0, 1'b0, 0, "R11 cfg uwrite");
        // R12 trailing bytes ignored
        run_cmd(2'd2, 1'b1, 1'b1, KEY, 8'h90, 8'd2, 1'b0, 1'b0, 3, "R12 trailing write");
        run_cmd(2'd1, 1'b0, 1'b1, KEY, 8'h90, 8'd2, 1'b0, 1'b0, 2, "R12 trailing read");
        run_fwd(3, "R12 fwd after trailing");

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [1:0] k;
            logic [7:0] a, l, ky;
            k  = 2'($urandom);
            a  = ($urandom % 4 == 0) ? 8'hFC + 8'($urandom % 4) : 8'($urandom);
            l  = ($urandom % 8 == 0) ? 8'($urandom % 7) : 8'd1 + 8'($urandom % MAXL);
            ky = ($urandom % 8 == 0) ? KEY ^ 8'h01 : KEY;
            if ($urandom % 6 == 0) run_fwd(1 + int'($urandom % 6), "R1 random fwd");
            run_cmd(k, 1'($urandom), ($urandom % 4 != 0), ky, a, l,
                    ($urandom % 8 == 0), ($urandom % 6 == 0), int'($urandom % 3),
                    "R2 R6 R7 R8 random");
        end

        finish_run();
    end
endmodule